// File: doc/BRIEF.md
# Wired/Radio Memory Access Arbiter

This block decides which of two requesters may touch a shared nonvolatile memory: a wired two-wire serial slave engine, or a radio command engine. It has three states. In internal control, both ports are shut out while the block runs its own work. That work is the start-up sequence, a memory write, or the execution of a radio command together with its reply. In wired control, only the serial engine is served. In idle/radio-receive, the radio side may receive commands, and a wired access may take over at any moment.

The protocol engines and the memory are outside this block. Each one reports its state through level or strobe inputs. The block answers with a grant and an ignore flag for each port, plus a one-cycle abort pulse that tells the radio engine to drop a reception that wired traffic has pre-empted. A supply-inhibit enable input governs the radio side. When it is low, the radio port is never served, even in idle. After reset the block stays in internal control for a fixed number of cycles before it becomes idle.

Top module: `nvm_port_arbiter`

## Requirements
- R1: While reset is asserted and after its release, the block is in internal control: wired_ignore=1, radio_ignore=1, both grants 0. It enters idle at the (INIT_CYCLES+1)-th rising edge after release, provided no busy input is high.
- R2: When init_busy, mem_wr_busy or reply_busy is high in idle, the block moves to internal control at the next edge. It stays in internal control while any of them is high.
- R3: In idle, a wired_id_match strobe moves the block to wired control at the next edge: wired_grant=1, wired_ignore=0, radio_grant=0, radio_ignore=1.
- R4: In internal control, wired_id_match and radio_cmd_rcvd are ignored. Internal control only ever leads to idle.
- R5: In wired control, a wired_stop with no write commanded during the transaction returns the block to idle at the next edge.
- R6: If wired_wr_cmd was seen during the wired transaction, up to and including the ending cycle, the end of the transaction leads to internal control instead of idle.
- R7: A wired_start_nomatch strobe in wired control ends the transaction exactly as wired_stop does.
- R8: In wired control, the block stays wired for as long as no ending strobe arrives, however long that is. radio_cmd_rcvd has no effect during that time.
- R9: radio_abort is high for exactly one cycle, in the first wired cycle, when the move from idle to wired happened while radio_rx_busy and radio_en were both high. Otherwise it stays low.
- R10: In idle with radio_en=1, radio_cmd_rcvd moves the block to internal control at the next edge.
- R11: With radio_en=0, radio_grant=0 and radio_ignore=1 in every state, and radio_cmd_rcvd in idle leaves the block idle.
- R12: Priority in idle: a busy input comes first, then wired_id_match, then radio_cmd_rcvd. A wired match in the same cycle as a radio command wins.
- R13: Every entry into internal control lasts at least two cycles, even when no busy input is high. This gives the external engine a cycle to raise its busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| init_busy | input | 1 | External initialisation in progress (level) |
| mem_wr_busy | input | 1 | Memory write in progress (level) |
| reply_busy | input | 1 | Radio reply being sent (level) |
| wired_id_match | input | 1 | Serial engine saw a start with a matching device ID (strobe) |
| wired_stop | input | 1 | Serial engine saw a stop condition (strobe) |
| wired_start_nomatch | input | 1 | Serial engine saw a start with a foreign device ID (strobe) |
| wired_wr_cmd | input | 1 | The current wired transaction commanded a memory write (strobe) |
| radio_cmd_rcvd | input | 1 | Radio engine finished receiving a command (strobe) |
| radio_rx_busy | input | 1 | Radio engine is currently receiving (level) |
| radio_en | input | 1 | Supply-inhibit enable; 0 keeps the radio port shut |
| wired_grant | output | 1 | Wired port owns the memory |
| wired_ignore | output | 1 | Wired traffic must be ignored |
| radio_grant | output | 1 | Radio port may receive commands |
| radio_ignore | output | 1 | Radio traffic must be ignored |
| radio_abort | output | 1 | One-cycle request to drop a radio reception in progress |

## Verification
Several properties are checked on every cycle: internal control never leads straight to wired control, wired control holds until an ending strobe, an abort only appears on the first cycle after idle, a busy input always forces internal control, and each internal entry lasts at least two cycles. Other behaviour depends on a sequence of strobes and can only be shown by the bench's scenarios. This covers the exact length of the start-up count, the choice between idle and internal at the end of a transaction depending on when the write strobe arrived, the priority among strobes that arrive together, and the radio-disabled paths. These sequences are also compared against a behavioural model on every clock under random strobe traffic.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_INT   = 2'd0,
    ST_WIRED = 2'd1,
    ST_IDLE  = 2'd2
  } arb_state_e;

  typedef struct packed {
    logic busy_any;
    logic id_match;
    logic stop;
    logic start_nomatch;
    logic wr_cmd;
    logic radio_cmd;
    logic radio_rx;
    logic radio_en;
  } arb_ev_t;

endpackage

// File: rtl/arb_init_timer.sv
module arb_init_timer #(
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = (INIT_CYCLES < 2) ? 1 : $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == LAST);
  assign cnt_en = !done;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_count_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  arb_ev_t    ev,
  input  logic       init_done,
  output arb_state_e state,
  output logic       abort
);
  arb_state_e state_q, state_d;
  logic       wr_q, wr_d;
  logic       hold_q, hold_d;
  logic       abort_q, abort_d;
  logic       end_xfer;
  logic       wr_seen;

  assign end_xfer = ev.stop | ev.start_nomatch;
  assign wr_seen  = wr_q | ev.wr_cmd;

  always_comb begin
    state_d = state_q;
    wr_d    = wr_q;
    hold_d  = 1'b0;
    abort_d = 1'b0;
    unique case (state_q)
      ST_INT: begin
        wr_d = 1'b0;
        if (init_done && !hold_q && !ev.busy_any) state_d = ST_IDLE;
      end
      ST_WIRED: begin
        if (ev.wr_cmd) wr_d = 1'b1;
        if (end_xfer) begin
          wr_d = 1'b0;
          if (wr_seen) begin
            state_d = ST_INT;
            hold_d  = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        wr_d = 1'b0;
        if (ev.busy_any) begin
          state_d = ST_INT;
          hold_d  = 1'b1;
        end else if (ev.id_match) begin
          state_d = ST_WIRED;
          abort_d = ev.radio_rx & ev.radio_en;
        end else if (ev.radio_cmd && ev.radio_en) begin
          state_d = ST_INT;
          hold_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_INT;
        wr_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INT;
      wr_q    <= 1'b0;
      hold_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      hold_q  <= hold_d;
      abort_q <= abort_d;
    end
  end

  assign state = state_q;
  assign abort = abort_q;

  // R4: internal control never hands over straight to the wired port
  p_int_not_wired_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INT) |=> (state_q != ST_WIRED));

  // R2: a busy level outside wired control forces internal control
  p_busy_internal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_WIRED) && ev.busy_any) |=> (state_q == ST_INT));

  // R8: wired control persists until an ending strobe
  p_wired_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WIRED) && !ev.stop && !ev.start_nomatch) |=> (state_q == ST_WIRED));

  // R9: abort only on the first wired cycle after idle
  p_abort_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> ((state_q == ST_WIRED) && ($past(state_q) == ST_IDLE)));

  // R10: an enabled radio command in a quiet idle starts internal control
  p_radio_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && ev.radio_en && ev.radio_cmd && !ev.id_match && !ev.busy_any)
      |=> (state_q == ST_INT));

  // R13: each fresh entry into internal control lasts at least two cycles
  p_int_min_dwell_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_INT) && ($past(state_q) != ST_INT)) |=> (state_q == ST_INT));

endmodule

// File: rtl/arb_port_decode.sv
module arb_port_decode
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  arb_state_e state,
  input  logic       radio_en,
  input  logic       abort_in,
  output logic       wired_grant,
  output logic       wired_ignore,
  output logic       radio_grant,
  output logic       radio_ignore,
  output logic       radio_abort
);
  logic radio_open;

  assign radio_open   = (state == ST_IDLE) && radio_en;
  assign wired_grant  = (state == ST_WIRED);
  assign wired_ignore = (state == ST_INT);
  assign radio_grant  = radio_open;
  assign radio_ignore = !radio_open;
  assign radio_abort  = abort_in;

  // R11: the radio port stays shut whenever the enable bit is low
  p_radio_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !radio_en |-> (!radio_grant && radio_ignore));

  // R3: at most one port is granted at a time
  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wired_grant && radio_grant));

endmodule

// File: rtl/nvm_port_arbiter.sv
module nvm_port_arbiter
  import arb_pkg::*;
#(
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_busy,
  input  logic mem_wr_busy,
  input  logic reply_busy,
  input  logic wired_id_match,
  input  logic wired_stop,
  input  logic wired_start_nomatch,
  input  logic wired_wr_cmd,
  input  logic radio_cmd_rcvd,
  input  logic radio_rx_busy,
  input  logic radio_en,
  output logic wired_grant,
  output logic wired_ignore,
  output logic radio_grant,
  output logic radio_ignore,
  output logic radio_abort
);
  arb_ev_t    ev;
  arb_state_e state;
  logic       init_done;
  logic       abort;

  always_comb begin
    ev.busy_any      = init_busy | mem_wr_busy | reply_busy;
    ev.id_match      = wired_id_match;
    ev.stop          = wired_stop;
    ev.start_nomatch = wired_start_nomatch;
    ev.wr_cmd        = wired_wr_cmd;
    ev.radio_cmd     = radio_cmd_rcvd;
    ev.radio_rx      = radio_rx_busy;
    ev.radio_en      = radio_en;
  end

  arb_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .done (init_done)
  );

  arb_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .init_done(init_done),
    .state    (state),
    .abort    (abort)
  );

  arb_port_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .radio_en    (radio_en),
    .abort_in    (abort),
    .wired_grant (wired_grant),
    .wired_ignore(wired_ignore),
    .radio_grant (radio_grant),
    .radio_ignore(radio_ignore),
    .radio_abort (radio_abort)
  );

  // R9: the abort request never lasts two cycles
  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    radio_abort |=> !radio_abort);

endmodule

// File: tb/nvm_port_arbiter_tb_top.sv
`timescale 1ns/1ps
module nvm_port_arbiter_tb_top;
  localparam int INIT_N = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic init_busy, mem_wr_busy, reply_busy;
  logic wired_id_match, wired_stop, wired_start_nomatch, wired_wr_cmd;
  logic radio_cmd_rcvd, radio_rx_busy, radio_en;
  logic wired_grant, wired_ignore, radio_grant, radio_ignore, radio_abort;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  nvm_port_arbiter #(.INIT_CYCLES(INIT_N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .init_busy(init_busy), .mem_wr_busy(mem_wr_busy), .reply_busy(reply_busy),
    .wired_id_match(wired_id_match), .wired_stop(wired_stop),
    .wired_start_nomatch(wired_start_nomatch), .wired_wr_cmd(wired_wr_cmd),
    .radio_cmd_rcvd(radio_cmd_rcvd), .radio_rx_busy(radio_rx_busy), .radio_en(radio_en),
    .wired_grant(wired_grant), .wired_ignore(wired_ignore),
    .radio_grant(radio_grant), .radio_ignore(radio_ignore), .radio_abort(radio_abort)
  );

  // Behavioural reference: 0 internal, 1 wired, 2 idle
  int m_st, m_cnt, n_st;
  bit m_hold, m_wr, m_ab, n_hold, n_wr, n_ab, busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_hold = 0; m_wr = 0; m_ab = 0;
    end else begin
      busy = init_busy || mem_wr_busy || reply_busy;
      n_st = m_st; n_hold = 0; n_ab = 0; n_wr = m_wr;
      if (m_st == 0) begin
        n_wr = 0;
        if (m_cnt >= INIT_N && !m_hold && !busy) n_st = 2;
      end else if (m_st == 1) begin
        if (wired_wr_cmd) n_wr = 1;
        if (wired_stop || wired_start_nomatch) begin
          n_wr = 0;
          if (m_wr || wired_wr_cmd) begin n_st = 0; n_hold = 1; end
          else n_st = 2;
        end
      end else begin
        n_wr = 0;
        if (busy) begin n_st = 0; n_hold = 1; end
        else if (wired_id_match) begin n_st = 1; n_ab = radio_rx_busy && radio_en; end
        else if (radio_cmd_rcvd && radio_en) begin n_st = 0; n_hold = 1; end
      end
      if (m_cnt < INIT_N) m_cnt = m_cnt + 1;
      m_st = n_st; m_hold = n_hold; m_wr = n_wr; m_ab = n_ab;
    end
  end

  task automatic cmp(string req, bit wg, bit wi, bit rg, bit ri, bit ab);
    checks++;
    if (wired_grant !== wg || wired_ignore !== wi || radio_grant !== rg ||
        radio_ignore !== ri || radio_abort !== ab) begin
      errors++;
      $display("FAIL %s: got wg=%b wi=%b rg=%b ri=%b ab=%b expected wg=%b wi=%b rg=%b ri=%b ab=%b",
               req, wired_grant, wired_ignore, radio_grant, radio_ignore, radio_abort,
               wg, wi, rg, ri, ab);
    end
  endtask

  // Per-cycle comparison against the model, away from the sampling edge
  always @(negedge clk) begin
    if (!finished) begin
      bit erg;
      erg = (m_st == 2) && radio_en;
      cmp({cur_req, " model"}, m_st == 1, m_st == 0, erg, !erg, m_ab);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic clr();
    wired_id_match = 0; wired_stop = 0; wired_start_nomatch = 0;
    wired_wr_cmd = 0; radio_cmd_rcvd = 0;
  endtask

  // expected outputs by state name: internal / wired / idle
  task automatic exp_int(string r);  cmp(r, 0, 1, 0, 1, 0); endtask
  task automatic exp_wired(string r, bit ab = 0); cmp(r, 1, 0, 0, 1, ab); endtask
  task automatic exp_idle(string r); cmp(r, 0, 0, radio_en, !radio_en, 0); endtask

  initial begin
    rst_n = 0; init_busy = 0; mem_wr_busy = 0; reply_busy = 0;
    radio_rx_busy = 0; radio_en = 1; clr();
    cyc(3);
    exp_int("R1 in reset");
    rst_n = 1;
    cyc(INIT_N);
    exp_int("R1 init count");
    cyc();
    exp_idle("R1 idle after init");

    cur_req = "R3";
    wired_id_match = 1; cyc(); clr();
    exp_wired("R3 grant");
    cur_req = "R8";
    radio_cmd_rcvd = 1; cyc(); clr();
    exp_wired("R8 radio ignored");
    cyc(5);
    exp_wired("R8 long hold");
    cur_req = "R5";
    wired_stop = 1; cyc(); clr();
    exp_idle("R5 stop to idle");

    cur_req = "R9";
    radio_rx_busy = 1; wired_id_match = 1; cyc(); clr();
    exp_wired("R9 abort pulse", 1);
    radio_rx_busy = 0; cyc();
    exp_wired("R9 abort one cycle", 0);
    cur_req = "R7";
    wired_start_nomatch = 1; cyc(); clr();
    exp_idle("R7 foreign start ends");

    cur_req = "R6";
    wired_id_match = 1; cyc(); clr();
    wired_wr_cmd = 1; cyc(); clr();
    cyc();
    wired_stop = 1; cyc(); clr();
    exp_int("R6 write leads to internal");
    cur_req = "R13";
    cyc();
    exp_int("R13 min dwell");
    cyc();
    exp_idle("R13 dwell ends");

    cur_req = "R2";
    mem_wr_busy = 1; cyc();
    exp_int("R2 busy entry");
    cur_req = "R4";
    wired_id_match = 1; radio_cmd_rcvd = 1; cyc(3); clr();
    exp_int("R4 strobes ignored");
    mem_wr_busy = 0; cyc();
    exp_idle("R2 busy released");

    cur_req = "R10";
    radio_cmd_rcvd = 1; cyc(); clr();
    reply_busy = 1;
    exp_int("R10 radio exec");
    cyc(4);
    exp_int("R2 reply busy");
    reply_busy = 0; cyc();
    exp_idle("R10 back to idle");

    cur_req = "R11";
    radio_en = 0; #1;
    exp_idle("R11 radio shut in idle");
    checks++;
    if (radio_grant !== 0 || radio_ignore !== 1) begin
      errors++;
      $display("FAIL R11: rg=%b ri=%b expected rg=0 ri=1", radio_grant, radio_ignore);
    end
    radio_cmd_rcvd = 1; cyc(); clr();
    exp_idle("R11 command ignored");
    radio_rx_busy = 1; wired_id_match = 1; cyc(); clr();
    exp_wired("R11 no abort when disabled", 0);
    radio_rx_busy = 0; wired_stop = 1; cyc(); clr();
    radio_en = 1;

    cur_req = "R12";
    wired_id_match = 1; radio_cmd_rcvd = 1; cyc(); clr();
    exp_wired("R12 wired wins");
    wired_wr_cmd = 1; wired_stop = 1; cyc(); clr();
    exp_int("R6 write on ending cycle");
    cyc(2);
    init_busy = 1; wired_id_match = 1; cyc(); clr();
    exp_int("R12 busy beats match");
    init_busy = 0; cyc(2);
    exp_idle("R2 init busy released");

    cur_req = "RAND";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      clr();
      wired_id_match      = (r < 15);
      wired_stop          = (r >= 15 && r < 25);
      wired_start_nomatch = (r >= 25 && r < 30);
      wired_wr_cmd        = ($urandom_range(0, 9) == 0);
      radio_cmd_rcvd      = ($urandom_range(0, 9) == 0);
      radio_rx_busy       = ($urandom_range(0, 2) == 0);
      mem_wr_busy         = ($urandom_range(0, 19) == 0);
      reply_busy          = ($urandom_range(0, 29) == 0);
      init_busy           = ($urandom_range(0, 49) == 0);
      if ($urandom_range(0, 49) == 0) radio_en = ~radio_en;
      cyc();
    end
    clr(); mem_wr_busy = 0; reply_busy = 0; init_busy = 0; radio_rx_busy = 0;
    cyc(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule